// File: doc/BRIEF.md
# User Mask Register with Sticky Floating-Point Write Flags

This block holds the user-visible mask byte of a processor core. Two of its bits are plain enables that software owns. Bit 2 turns user performance monitoring on. Bit 3 selects strict alignment checking. Two further bits are sticky status flags that hardware raises. Bit 4 records that some lower floating-point register was the target of a completing instruction. Bit 5 records the same for the upper bank.

Every cycle the block takes one instruction-completion report. The report carries a valid bit, a flag saying the target is a floating-point register, and the target register number. The block decodes the register range and sets the matching flag.

Software loads the whole mask through an explicit write port. That write is the only way to clear a flag. When a write and a flag-setting completion arrive in the same cycle, the written value is taken and the completion's flag is then set on top of it. The register bank size and the two range boundaries are parameters.

Top module: `umask_reg`

## Requirements
- R1: After reset, all bits of `mask_q` read 0, and `perf_mon_en` and `align_strict` are 0.
- R2: With `wr_en` high at a clock edge, bits 2 to 5 of `mask_q` take bits 2 to 5 of `wr_data` from the next cycle on. The same edge updates `perf_mon_en` to `mask_q[2]` and `align_strict` to `mask_q[3]`.
- R3: Bits 0, 1, 6 and 7 of `mask_q` always read 0, even when written with 1.
- R4: A report with `cmp_valid`=1, `cmp_fp`=1 and `cmp_reg` in 2..31 sets `mask_q[4]` at the next edge.
- R5: A report with `cmp_valid`=1, `cmp_fp`=1 and `cmp_reg` in 32..127 sets `mask_q[5]` at the next edge.
- R6: A floating-point report targeting register 0 or 1 sets neither flag.
- R7: A report with `cmp_valid`=0, or with `cmp_fp`=0, changes no mask bit.
- R8: Once set, bits 4 and 5 stay 1 until a write. A write carrying 0 in a flag bit clears that flag.
- R9: When a write and a flag-setting report share an edge, the next value is the written value with the report's flag forced to 1.
- R10: Completion reports never change bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Explicit software load of the mask |
| wr_data | input | MASK_W (8) | Value loaded on a write |
| cmp_valid | input | 1 | Completion report present this cycle |
| cmp_fp | input | 1 | Completing instruction targets a floating-point register |
| cmp_reg | input | IDX_W (7) | Target register number |
| mask_q | output | MASK_W (8) | Current mask value |
| perf_mon_en | output | 1 | User performance monitoring enabled (bit 2) |
| align_strict | output | 1 | Strict alignment checking selected (bit 3) |

## Verification
The bench builds the block with its defaults: 128 floating-point registers, the lower range starting at 2 and the upper range at 32. With these values the 7-bit register field covers every index. That puts the constant registers 0 and 1, both edges of each range (1/2, 31/32) and the top index 127 within reach of directed tests. Because 32 is a power of two and the bank fills the index field, the high-bit range decoder is the variant exercised. Random traffic mixes writes, invalid reports and non-floating-point reports with floating-point completions, so sticky holding and same-cycle write priority occur many times.

// File: rtl/umask_pkg.sv
`timescale 1ns/1ps
package umask_pkg;

   typedef enum logic [1:0] {
      UM_RSVD      = 2'd0,
      UM_CTRL      = 2'd1,
      UM_STICKY_LO = 2'd2,
      UM_STICKY_HI = 2'd3
   } um_kind_e;

   localparam int UM_PERF_BIT  = 2;
   localparam int UM_ALIGN_BIT = 3;
   localparam int UM_LO_BIT    = 4;
   localparam int UM_HI_BIT    = 5;
   localparam int UM_MIN_W     = 6;

   function automatic um_kind_e um_kind(input int pos);
      um_kind_e k;
      case (pos)
         UM_PERF_BIT, UM_ALIGN_BIT: k = UM_CTRL;
         UM_LO_BIT:                 k = UM_STICKY_LO;
         UM_HI_BIT:                 k = UM_STICKY_HI;
         default:                   k = UM_RSVD;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/umask_fr_range.sv
`timescale 1ns/1ps
module umask_fr_range #(
   parameter int FPR_COUNT   = 128,
   parameter int FIRST_LOWER = 2,
   parameter int FIRST_UPPER = 32,
   parameter int IDX_W       = $clog2(FPR_COUNT)
) (
   input  logic             rpt_valid,
   input  logic             rpt_fp,
   input  logic [IDX_W-1:0] rpt_idx,
   output logic             set_lo,
   output logic             set_hi
);

   localparam logic [IDX_W-1:0] LO_BASE   = IDX_W'(FIRST_LOWER);
   localparam logic [IDX_W-1:0] HI_BASE   = IDX_W'(FIRST_UPPER);
   localparam logic [IDX_W:0]   IDX_LIMIT = (IDX_W+1)'(FPR_COUNT);
   localparam bit   UP_IS_POW2 = (FIRST_UPPER & (FIRST_UPPER - 1)) == 0;
   localparam bit   FULL_BANK  = FPR_COUNT == (1 << IDX_W);
   localparam int   UP_SHIFT   = $clog2(FIRST_UPPER);

   logic rpt_take;
   logic in_lo;
   logic in_hi;

   assign rpt_take = rpt_valid & rpt_fp;

   if (UP_IS_POW2 && FULL_BANK) begin : g_highbit
      // upper bank starts on a power of two and fills the index field:
      // any set bit above the boundary position means an upper register
      logic hi_raw;
      assign hi_raw = |rpt_idx[IDX_W-1:UP_SHIFT];
      assign in_hi  = hi_raw;
      assign in_lo  = !hi_raw && (rpt_idx >= LO_BASE);
   end else begin : g_compare
      assign in_lo = (rpt_idx >= LO_BASE) && (rpt_idx < HI_BASE);
      assign in_hi = (rpt_idx >= HI_BASE) && ({1'b0, rpt_idx} < IDX_LIMIT);
   end

   assign set_lo = rpt_take & in_lo;
   assign set_hi = rpt_take & in_hi;

endmodule

// File: rtl/umask_ctrl_bit.sv
`timescale 1ns/1ps
module umask_ctrl_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (wr_en) q <= wr_val;
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q)); // R10

endmodule

// File: rtl/umask_sticky_bit.sv
`timescale 1ns/1ps
module umask_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic set_i,
   output logic q
);

   logic base;
   logic q_next;

   // software write replaces the held value; a hardware set always lands
   assign base   = wr_en ? wr_val : q;
   assign q_next = base | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_next;
   end

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !wr_en) |=> q); // R8
   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_val && !set_i) |=> !q); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q); // R9

endmodule

// File: rtl/umask_reg.sv
`timescale 1ns/1ps
module umask_reg
   import umask_pkg::*;
#(
   parameter int MASK_W      = 8,
   parameter int FPR_COUNT   = 128,
   parameter int FIRST_LOWER = 2,
   parameter int FIRST_UPPER = 32,
   parameter int IDX_W       = $clog2(FPR_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MASK_W-1:0] wr_data,
   input  logic              cmp_valid,
   input  logic              cmp_fp,
   input  logic [IDX_W-1:0]  cmp_reg,
   output logic [MASK_W-1:0] mask_q,
   output logic              perf_mon_en,
   output logic              align_strict
);

   if (MASK_W < UM_MIN_W) begin : g_bad_width
      $error("umask_reg: MASK_W must hold the flag bits");
   end
   if (FIRST_LOWER < 1 || FIRST_LOWER >= FIRST_UPPER) begin : g_bad_lower
      $error("umask_reg: FIRST_LOWER must lie in 1..FIRST_UPPER-1");
   end
   if (FIRST_UPPER >= FPR_COUNT) begin : g_bad_upper
      $error("umask_reg: FIRST_UPPER must be below FPR_COUNT");
   end
   if ((1 << IDX_W) < FPR_COUNT) begin : g_bad_idx
      $error("umask_reg: IDX_W too narrow for FPR_COUNT");
   end

   localparam logic [IDX_W-1:0] LO_BASE = IDX_W'(FIRST_LOWER);
   localparam logic [IDX_W-1:0] HI_BASE = IDX_W'(FIRST_UPPER);

   logic              set_lo;
   logic              set_hi;
   logic [MASK_W-1:0] mask_bits;

   umask_fr_range #(
      .FPR_COUNT  (FPR_COUNT),
      .FIRST_LOWER(FIRST_LOWER),
      .FIRST_UPPER(FIRST_UPPER),
      .IDX_W      (IDX_W)
   ) u_range (
      .rpt_valid(cmp_valid),
      .rpt_fp   (cmp_fp),
      .rpt_idx  (cmp_reg),
      .set_lo   (set_lo),
      .set_hi   (set_hi)
   );

   for (genvar i = 0; i < MASK_W; i++) begin : g_bit
      if (um_kind(i) == UM_CTRL) begin : g_ctrl
         umask_ctrl_bit u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .wr_val(wr_data[i]),
            .q     (mask_bits[i])
         );
      end else if (um_kind(i) == UM_STICKY_LO) begin : g_lo
         umask_sticky_bit u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .wr_val(wr_data[i]),
            .set_i (set_lo),
            .q     (mask_bits[i])
         );
      end else if (um_kind(i) == UM_STICKY_HI) begin : g_hi
         umask_sticky_bit u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .wr_val(wr_data[i]),
            .set_i (set_hi),
            .q     (mask_bits[i])
         );
      end else begin : g_rsvd
         logic unused_rsvd_wr;
         assign unused_rsvd_wr = wr_data[i];
         assign mask_bits[i]   = 1'b0;
      end
   end

   assign mask_q       = mask_bits;
   assign perf_mon_en  = mask_bits[UM_PERF_BIT];
   assign align_strict = mask_bits[UM_ALIGN_BIT];

   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_q[UM_ALIGN_BIT:UM_PERF_BIT] == $past(wr_data[UM_ALIGN_BIT:UM_PERF_BIT]))); // R2
   AST_LOWER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_fp && cmp_reg >= LO_BASE && cmp_reg < HI_BASE) |=> mask_q[UM_LO_BIT]); // R4
   AST_UPPER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_fp && cmp_reg >= HI_BASE) |=> mask_q[UM_HI_BIT]); // R5
   AST_CONST_REG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && cmp_valid && cmp_fp && cmp_reg < LO_BASE) |=> $stable(mask_q)); // R6
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(cmp_valid && cmp_fp)) |=> $stable(mask_q)); // R7

endmodule

// File: tb/umask_reg_bench.sv
`timescale 1ns/1ps
module umask_reg_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cmp_valid = 1'b0;
   logic       cmp_fp = 1'b0;
   logic [6:0] cmp_reg = '0;
   logic [7:0] mask_q;
   logic       perf_mon_en;
   logic       align_strict;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_mask = '0;

   always #2 clk = ~clk;

   umask_reg u_umask_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cmp_valid(cmp_valid), .cmp_fp(cmp_fp), .cmp_reg(cmp_reg),
      .mask_q(mask_q), .perf_mon_en(perf_mon_en), .align_strict(align_strict)
   );

   function automatic logic [7:0] model_next(input logic [7:0] cur, input logic w,
                                             input logic [7:0] wd, input logic v,
                                             input logic fp, input logic [6:0] r);
      logic [7:0] n;
      n = w ? (wd & 8'h3C) : cur;
      if (v && fp && r >= 7'd2 && r < 7'd32) n[4] = 1'b1;
      if (v && fp && r >= 7'd32)             n[5] = 1'b1;
      return n;
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic step(input string tag, input logic w, input logic [7:0] wd,
                       input logic v, input logic fp, input logic [6:0] r);
      @(negedge clk);
      wr_en = w; wr_data = wd; cmp_valid = v; cmp_fp = fp; cmp_reg = r;
      exp_mask = model_next(exp_mask, w, wd, v, fp, r);
      @(posedge clk);
      #1;
      check(tag, mask_q, exp_mask);
      check(tag, {6'd0, align_strict, perf_mon_en}, {6'd0, exp_mask[3], exp_mask[2]});
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      #9;
      check("R1 reset mask", mask_q, 8'h00);
      check("R1 reset enables", {6'd0, align_strict, perf_mon_en}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      step("R2 write enables", 1, 8'h0C, 0, 0, 7'd0);
      step("R2 write perf only", 1, 8'h04, 0, 0, 7'd0);
      step("R3 reserved bits ignored", 1, 8'hFF, 0, 0, 7'd0);
      step("R3 reserved alone", 1, 8'hC3, 0, 0, 7'd0);
      step("R6 reg0 no set", 0, 8'h00, 1, 1, 7'd0);
      step("R6 reg1 no set", 0, 8'h00, 1, 1, 7'd1);
      step("R7 invalid report", 0, 8'h00, 0, 1, 7'd40);
      step("R7 non-fp report", 0, 8'h00, 1, 0, 7'd10);
      step("R4 reg2 sets lower", 0, 8'h00, 1, 1, 7'd2);
      step("R8 lower holds", 0, 8'h00, 0, 0, 7'd0);
      step("R8 write clears", 1, 8'h08, 0, 0, 7'd0);
      step("R4 reg31 sets lower", 0, 8'h00, 1, 1, 7'd31);
      step("R5 reg32 sets upper", 0, 8'h00, 1, 1, 7'd32);
      step("R10 report keeps enables", 0, 8'h00, 1, 1, 7'd5);
      step("R8 write clears both", 1, 8'h00, 0, 0, 7'd0);
      step("R5 reg127 sets upper", 0, 8'h00, 1, 1, 7'd127);
      step("R9 write with lower set", 1, 8'h04, 1, 1, 7'd20);
      step("R9 write with upper set", 1, 8'h08, 1, 1, 7'd64);
      step("R8 write zero clears", 1, 8'h00, 0, 0, 7'd0);
      step("R6 reg1 with write", 1, 8'h00, 1, 1, 7'd1);

      for (int i = 0; i < 3000; i++) begin
         logic       w;
         logic [7:0] wd;
         logic       v;
         logic       fp;
         logic [6:0] r;
         int         pick;
         w  = ($urandom % 8) == 0;
         wd = 8'($urandom);
         v  = ($urandom % 4) != 0;
         fp = ($urandom % 3) != 0;
         pick = $urandom % 6;
         case (pick)
            0:       r = 7'($urandom % 2);
            1:       r = 7'd31 + 7'($urandom % 2);
            2:       r = 7'd127;
            default: r = 7'($urandom);
         endcase
         step("R9 random traffic", w, wd, v, fp, r);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule